// File: doc/BRIEF.md
# Daisy-Chain Device-ID Decrementing Forwarder

This block sits on the serial input of one device in a chain of slaves that share a single select line. It passes the incoming serial stream to a forwarding output for the next device downstream. While the control byte passes through, it lowers the 4-bit device-ID field by one. The field is stored with its least significant bit sent first, inside a byte that is otherwise sent most significant bit first. Because of that order, the subtraction is done bit-serially with a borrow flip-flop and no byte buffer.

Each device therefore sees ID 0 exactly when it is the addressed one, and the block raises a flag in that case. Address and data bytes, and the upper four control bits, pass through unchanged.

The serial clock, select and data inputs are sampled in the system clock domain and must already be synchronised to it. A rising serial-clock edge is detected as high now and low on the previous system clock.

Top module: `daisy_id_fwd`

## Requirements
- R1: After reset, `thru_o` and `addressed_o` are low and the position is at bit 0 of the control byte.
- R2: On each rising `sclk_i` edge with `cs_ni` low, the bit on `mosi_i` is forwarded on `thru_o` from the next system clock and held until the next such edge. Address and data bytes (frame bytes 1 and 2) are forwarded unmodified.
- R3: Control-byte bits 7:4, sent first, are forwarded unmodified.
- R4: Control-byte bits 3:0 hold the ID with bit 3 as ID bit 0 and bit 0 as ID bit 3. The forwarded field carries (ID − 1) mod 16 in the same bit order.
- R5: A received ID of 0 is forwarded as 15, which is all four field bits set.
- R6: `addressed_o` goes high, together with the eighth control bit on `thru_o`, when all four received ID bits were zero, and low otherwise. It holds through the address and data bytes. It clears on the first bit of the next control byte or on a resync.
- R7: A deselect (`cs_ni` rising) after exactly eight bits advances to the next byte: control, then address, then data, then control again. A byte that carries more than eight bits stops the advance, and every later bit is forwarded unmodified until a resync.
- R8: A rising `sclk_i` edge while `cs_ni` is high returns the position to bit 0 of the control byte.
- R9: `thru_o` and `addressed_o` change only on a rising `sclk_i` edge, and `thru_o` only while `cs_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, synchronised |
| cs_ni | input | 1 | Shared select, active low |
| mosi_i | input | 1 | Serial data in from upstream |
| thru_o | output | 1 | Serial data forwarded downstream |
| addressed_o | output | 1 | Received ID was zero |

## Verification
Every result of this block is registered once, at the system clock on which a rising serial-clock edge is first seen. This applies to the forwarded bit, the addressed flag and the position. The bench raises the serial clock on a falling system-clock edge and waits two falling edges before it samples `thru_o`, so each forwarded bit is read one full system clock after it was due. The addressed flag is read only after the eighth control bit and after the last data bit, which are the points where its value is defined.

// File: rtl/daisy_id_fwd_pkg.sv
package daisy_id_fwd_pkg;
  localparam int unsigned BITS_PER_BYTE   = 8;
  localparam int unsigned BYTES_PER_FRAME = 3;
  localparam int unsigned ID_BITS         = 4;
endpackage

// File: rtl/daisy_id_fwd_edge.sv
module daisy_id_fwd_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  output logic shift_o,
  output logic resync_o,
  output logic desel_o
);
  logic sclk_q, cs_q, rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
    end
  end

  assign rise     = sclk_i & ~sclk_q;
  assign shift_o  = rise & ~cs_ni;
  assign resync_o = rise & cs_ni;
  assign desel_o  = cs_ni & ~cs_q;
endmodule

// File: rtl/daisy_id_fwd_track.sv
module daisy_id_fwd_track #(
  parameter int unsigned BITS   = 8,
  parameter int unsigned BYTES  = 3,
  parameter int unsigned ID_W   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic resync_i,
  input  logic desel_i,
  output logic in_id_o,
  output logic id_first_o,
  output logic id_last_o,
  output logic ctrl_first_o,
  output logic frame_start_o
);
  localparam int unsigned CNT_W    = $clog2(BITS + 2);
  localparam int unsigned BYTE_W   = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int unsigned ID_START = BITS - ID_W;
  localparam logic [CNT_W-1:0]  CNT_FULL  = CNT_W'(BITS);
  localparam logic [CNT_W-1:0]  CNT_OVER  = CNT_W'(BITS + 1);
  localparam logic [CNT_W-1:0]  CNT_IDS   = CNT_W'(ID_START);
  localparam logic [CNT_W-1:0]  CNT_IDL   = CNT_W'(BITS - 1);
  localparam logic [BYTE_W-1:0] BYTE_LAST = BYTE_W'(BYTES - 1);

  logic [CNT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] byte_q;
  logic              in_ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      byte_q <= '0;
    end else if (resync_i) begin
      bit_q  <= '0;
      byte_q <= '0;
    end else if (shift_i) begin
      if (bit_q != CNT_OVER) bit_q <= bit_q + 1'b1;
    end else if (desel_i && bit_q == CNT_FULL) begin
      bit_q  <= '0;
      byte_q <= (byte_q == BYTE_LAST) ? '0 : byte_q + 1'b1;
    end
  end

  assign in_ctrl       = (byte_q == '0);
  assign in_id_o       = in_ctrl && bit_q >= CNT_IDS && bit_q < CNT_FULL;
  assign id_first_o    = in_ctrl && bit_q == CNT_IDS;
  assign id_last_o     = in_ctrl && bit_q == CNT_IDL;
  assign ctrl_first_o  = in_ctrl && bit_q == '0;
  assign frame_start_o = ctrl_first_o;
endmodule

// File: rtl/daisy_id_fwd_dec.sv
module daisy_id_fwd_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic first_i,
  input  logic bit_i,
  output logic bit_o,
  output logic zero_o
);
  logic borrow_q, zero_q, borrow_eff, zero_eff;

  // field arrives LSB first: preset borrow on its first bit
  assign borrow_eff = first_i | borrow_q;
  assign zero_eff   = first_i | zero_q;
  assign bit_o      = bit_i ^ borrow_eff;
  assign zero_o     = zero_eff & ~bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      borrow_q <= 1'b0;
      zero_q   <= 1'b0;
    end else if (en_i) begin
      borrow_q <= borrow_eff & ~bit_i;
      zero_q   <= zero_eff & ~bit_i;
    end
  end
endmodule

// File: rtl/daisy_id_fwd.sv
module daisy_id_fwd
  import daisy_id_fwd_pkg::*;
#(
  parameter int unsigned BITS  = BITS_PER_BYTE,
  parameter int unsigned BYTES = BYTES_PER_FRAME,
  parameter int unsigned ID_W  = ID_BITS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic thru_o,
  output logic addressed_o
);
  logic shift, resync, desel;
  logic in_id, id_first, id_last, ctrl_first, frame_start;
  logic dec_bit, dec_zero, fwd_bit;
  logic thru_q, addr_q;

  daisy_id_fwd_edge u_edge (
    .clk_i, .rst_ni, .sclk_i, .cs_ni,
    .shift_o(shift), .resync_o(resync), .desel_o(desel)
  );

  daisy_id_fwd_track #(.BITS(BITS), .BYTES(BYTES), .ID_W(ID_W)) u_track (
    .clk_i, .rst_ni,
    .shift_i(shift), .resync_i(resync), .desel_i(desel),
    .in_id_o(in_id), .id_first_o(id_first), .id_last_o(id_last),
    .ctrl_first_o(ctrl_first), .frame_start_o(frame_start)
  );

  daisy_id_fwd_dec u_dec (
    .clk_i, .rst_ni,
    .en_i(shift & in_id), .first_i(id_first), .bit_i(mosi_i),
    .bit_o(dec_bit), .zero_o(dec_zero)
  );

  assign fwd_bit = in_id ? dec_bit : mosi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thru_q <= 1'b0;
      addr_q <= 1'b0;
    end else if (resync) begin
      addr_q <= 1'b0;
    end else if (shift) begin
      thru_q <= fwd_bit;
      if (ctrl_first)   addr_q <= 1'b0;
      else if (id_last) addr_q <= dec_zero;
    end
  end

  assign thru_o      = thru_q;
  assign addressed_o = addr_q;
endmodule

// File: rtl/daisy_id_fwd_chk.sv
module daisy_id_fwd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_i,
  input logic cs_ni,
  input logic mosi_i,
  input logic thru_o,
  input logic addressed_o,
  input logic in_id,
  input logic frame_start
);
  logic sclk_d;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_i;

  // R2
  plain_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i && !sclk_d && !cs_ni && !in_id) |=> (thru_o == $past(mosi_i)));
  // R9
  thru_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(sclk_i && !sclk_d) || cs_ni) |=> $stable(thru_o));
  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sclk_i && !sclk_d) |=> $stable(addressed_o));
  // R8
  resync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i && !sclk_d && cs_ni) |=> frame_start);
  // R5
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addressed_o) |-> thru_o);
endmodule

bind daisy_id_fwd daisy_id_fwd_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .cs_ni(cs_ni),
  .mosi_i(mosi_i), .thru_o(thru_o), .addressed_o(addressed_o),
  .in_id(in_id), .frame_start(frame_start)
);

// File: tb/daisy_id_fwd_bench.sv
`timescale 1ns/1ps
module daisy_id_fwd_bench;
  logic clk_i = 1'b0, rst_ni = 1'b0, sclk_i = 1'b0, cs_ni = 1'b1, mosi_i = 1'b0;
  logic thru_o, addressed_o;
  int errs = 0, checks = 0;

  always #2.5 clk_i = ~clk_i;

  daisy_id_fwd u_daisy_id_fwd (.*);

  // {flags[3:0], id[3:0], addr[7:0], data[7:0]}
  localparam logic [23:0] VEC [16] = '{
    24'h8_0_12_34, 24'h0_1_A5_5A, 24'h4_2_FF_00, 24'hC_3_00_FF,
    24'h1_4_3C_C3, 24'h2_5_81_7E, 24'h3_6_55_AA, 24'hF_7_01_80,
    24'h8_8_7F_FE, 24'h4_9_C0_03, 24'h0_A_99_66, 24'hC_B_10_08,
    24'h6_C_E7_18, 24'h9_D_0F_F0, 24'h5_E_24_42, 24'hA_F_DB_BD
  };

  function automatic logic [3:0] rev4(input logic [3:0] v);
    return {v[0], v[1], v[2], v[3]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bit_out(input logic b, output logic f);
    mosi_i = b; sclk_i = 1'b0; tick(2);
    sclk_i = 1'b1; tick(2);
    f = thru_o;
    sclk_i = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] b, input int nbits, output logic [7:0] f);
    logic fb;
    cs_ni = 1'b0; tick(2);
    f = '0;
    for (int i = 0; i < nbits; i++) begin
      bit_out(b[7 - (i % 8)], fb);
      f = {f[6:0], fb};
    end
    tick(2); cs_ni = 1'b1; tick(3);
  endtask

  task automatic resync();
    cs_ni = 1'b1; mosi_i = ~mosi_i; tick(1);
    sclk_i = 1'b1; tick(2);
    sclk_i = 1'b0; tick(2);
  endtask

  initial begin
    #1000000;
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] fc, fa, fd, f2;
    logic       held;
    tick(3);
    chk("R1 thru_o after reset", 32'(thru_o), 0);
    chk("R1 addressed_o after reset", 32'(addressed_o), 0);
    rst_ni = 1'b1; tick(2);

    // frames back to back, no resync: also covers R7 byte advance
    for (int k = 0; k < 16; k++) begin
      logic [3:0] fl, id;
      fl = VEC[k][23:20]; id = VEC[k][19:16];
      xfer({fl, rev4(id)}, 8, fc);
      chk("R6 addressed after control byte", 32'(addressed_o), 32'(id == 4'd0));
      xfer(VEC[k][15:8], 8, fa);
      xfer(VEC[k][7:0], 8, fd);
      chk("R3 control flags", 32'(fc[7:4]), 32'(fl));
      if (id == 4'd0) chk("R5 id 0 wraps", 32'(rev4(fc[3:0])), 15);
      else            chk("R4 R7 id decremented", 32'(rev4(fc[3:0])), 32'(id - 4'd1));
      chk("R2 address byte", 32'(fa), 32'(VEC[k][15:8]));
      chk("R2 data byte", 32'(fd), 32'(VEC[k][7:0]));
      chk("R6 addressed holds", 32'(addressed_o), 32'(id == 4'd0));
    end

    // R6 clear on first bit of next control byte
    resync();
    xfer({4'h0, rev4(4'd0)}, 8, fc);
    xfer(8'h11, 8, fa); xfer(8'h22, 8, fd);
    chk("R6 set for id 0", 32'(addressed_o), 1);
    xfer(8'h00, 1, fc);
    chk("R6 cleared at next control start", 32'(addressed_o), 0);

    // R9 resync edges leave thru_o alone
    held = thru_o;
    resync(); resync();
    chk("R9 thru_o stable while deselected", 32'(thru_o), 32'(held));

    // R8 resync mid-frame
    resync();
    xfer({4'h2, rev4(4'd5)}, 8, fc);
    xfer(8'h40, 8, fa);
    resync();
    xfer({4'h2, rev4(4'd9)}, 8, fc);
    chk("R8 next byte treated as control", 32'(rev4(fc[3:0])), 8);

    // R7 overrun byte blocks advance and decrement
    resync();
    xfer({4'h0, rev4(4'd6)}, 9, fc);
    xfer({4'h0, rev4(4'd6)}, 8, f2);
    chk("R7 after overrun bits pass unchanged", 32'(f2), 32'({4'h0, rev4(4'd6)}));
    resync();
    xfer({4'h0, rev4(4'd6)}, 8, fc);
    chk("R7 recovers after resync", 32'(rev4(fc[3:0])), 5);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule